// File: doc/BRIEF.md
# Word-Serial Big-Number Vector Unit

This unit performs simple arithmetic on long unsigned integers kept in a local RAM that is 32 bits wide. Each operand is named by the RAM word address of its least significant word and by its length in words. The unit walks the operand words one at a time, writes each result word to a result area, and can copy, compare, add, subtract or shift a vector left or right by 0 to 31 bits. The RAM stays outside the block. The unit issues at most one read per cycle, and read data returns one cycle after the request.

When an operation finishes, the unit reports results through separate outputs. A compare reports a one-hot three-way flag. Every operation that writes a result reports the RAM address of the most significant nonzero result word, and sets a flag when the whole result is zero. On request it also reports the bit index of the highest set bit inside that word. These outputs change only on the edge that ends an operation, so a host can read the previous outcome while the next operation is running.

Top module: `bignum_vec_unit`

## Requirements
- R1: Operation code 0 (and the unused codes 6 and 7) copies aLen words from aPtr+i to resPtr+i, in order from the lowest word to the highest.
- R2: Code 2 adds A and B from the least significant word upward with a carry, and zero-extends the shorter operand. It writes max(aLen,bLen)+1 words, and the last word holds the final carry.
- R3: Code 3 writes A minus B modulo 2^(32*max(aLen,bLen)) as max(aLen,bLen) words, working upward with a borrow. A shorter operand is zero-extended.
- R4: Code 4 shifts A left by shiftAmt bits into aLen+1 words, written upward. Code 5 shifts A right by shiftAmt bits into aLen words, written downward from the top, with zeros shifted in at the top.
- R5: Code 1 compares A with B starting at the most significant word and stops at the first word that differs. A shorter vector counts as zero-extended. No word is written. cmpFlags is one-hot: bit 0 means A equals B, bit 1 means A is less than B, bit 2 means A is greater than B.
- R6: After any writing operation, mswStatus[10:0] holds the RAM address of the most significant nonzero result word. If every result word is zero, mswStatus reads 16'h8000: bit 15 is set and the address field is 0.
- R7: After a writing operation with msOneReq high, msBitPos holds the index (0 to 31) of the highest set bit of that word, or 0 for a zero result. With msOneReq low, or after a compare, msBitPos keeps its old value.
- R8: Result outputs change only at completion. cmpFlags changes only at the end of a compare, and mswStatus only at the end of a writing operation. All three outputs are stable while busy is high.
- R9: Each processed word takes three cycles: read A, read B, then execute and write. done is a one-cycle pulse in cycle 3*W+1 after the edge that samples start, where W is the number of words processed (for a compare, the words examined). If the operation has zero words, done comes in cycle 2. busy is high from cycle 1 through the done cycle.
- R10: A start pulse seen while busy is high is ignored. It changes neither the results nor the timing.
- R11: After reset busy and done are low, no RAM access is made, cmpFlags is 0, mswStatus is 16'h8000 and msBitPos is 0.
- R12: Each read stays inside the bounds of its operand (aPtr to aPtr+aLen-1, or bPtr to bPtr+bLen-1). A read and a write never fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the unit is idle |
| opSel | input | 3 | Operation code |
| msOneReq | input | 1 | Request for the highest-bit index |
| shiftAmt | input | 5 | Shift distance in bits |
| aPtr | input | 11 | Word address of the lowest word of A |
| aLen | input | 9 | Length of A in words |
| bPtr | input | 11 | Word address of the lowest word of B |
| bLen | input | 9 | Length of B in words |
| resPtr | input | 11 | Word address of the lowest result word |
| ramRdEn | output | 1 | RAM read request |
| ramRdAddr | output | 11 | RAM read address |
| ramRdData | input | 32 | Read data, one cycle after the request |
| ramWrEn | output | 1 | RAM write strobe |
| ramWrAddr | output | 11 | RAM write address |
| ramWrData | output | 32 | RAM write data |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| cmpFlags | output | 3 | One-hot compare outcome |
| mswStatus | output | 16 | Bit 15 zero flag, bits 10:0 address of the top nonzero word |
| msBitPos | output | 5 | Highest set bit within the top nonzero word |

## Verification
Result word i is written in cycle 3*i+3 after start is sampled, counting in processing order. The finished outputs are due in cycle 3*W+1, the same cycle as done. The bench starts counting cycles on the edge that samples start. It samples at the falling edge, matches every write against a queue of expected address and data pairs as the write happens, and checks on every cycle that done is high only in the expected cycle and that the published outputs do not move before it. The compare cases use operands that differ at different depths, so that early stopping shows up as a different cycle count.

// File: rtl/bnv_pkg.sv
package bnv_pkg;
  localparam logic [2:0] OP_COPY = 3'd0;
  localparam logic [2:0] OP_CMP  = 3'd1;
  localparam logic [2:0] OP_ADD  = 3'd2;
  localparam logic [2:0] OP_SUB  = 3'd3;
  localparam logic [2:0] OP_LSH  = 3'd4;
  localparam logic [2:0] OP_RSH  = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // new operation accepted
    logic capA;     // latch operand A from read data
    logic exec;     // execute and write one word
    logic dataOk;   // read data of this cycle belongs to a real read
    logic publish;  // final edge: update result outputs
    logic down;     // words are processed top to bottom
  } bnvStrobe_t;
endpackage

// File: rtl/bnv_ctrl.sv
module bnv_ctrl
  import bnv_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 9,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opIn,
  input  logic              msOneIn,
  input  logic [SH_W-1:0]   shiftIn,
  input  logic [ADDR_W-1:0] aPtrIn,
  input  logic [LEN_W-1:0]  aLenIn,
  input  logic [ADDR_W-1:0] bPtrIn,
  input  logic [LEN_W-1:0]  bLenIn,
  input  logic [ADDR_W-1:0] resPtrIn,
  input  logic              cmpDiff,
  output bnvStrobe_t        strb,
  output logic [2:0]        opQ,
  output logic              msOneQ,
  output logic [SH_W-1:0]   shiftQ,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramRdAddr,
  output logic              ramWrEn,
  output logic [ADDR_W-1:0] ramWrAddr,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_RDA, S_RDB, S_EXEC, S_EMPTY, S_DONE} state_e;
  state_e state;

  logic [ADDR_W-1:0] aPtrQ, bPtrQ, resPtrQ;
  logic [CNT_W-1:0]  aLenQ, bLenQ, idx, cnt;
  logic [CNT_W-1:0]  maxLen, total;
  logic              downIn, twoIn, downQ, twoQ, rdValidQ;
  logic              accept, finishWord;

  always_comb begin
    maxLen = (aLenIn > bLenIn) ? CNT_W'(aLenIn) : CNT_W'(bLenIn);
    case (opIn)
      OP_CMP, OP_SUB: total = maxLen;
      OP_ADD:         total = maxLen + 1'b1;
      OP_LSH:         total = CNT_W'(aLenIn) + 1'b1;
      default:        total = CNT_W'(aLenIn);
    endcase
    downIn = (opIn == OP_CMP) || (opIn == OP_RSH);
    twoIn  = (opIn == OP_CMP) || (opIn == OP_ADD) || (opIn == OP_SUB);
  end

  assign accept     = start && (state == S_IDLE);
  assign finishWord = (state == S_EXEC) && ((cnt == CNT_W'(1)) || ((opQ == OP_CMP) && cmpDiff));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      aPtrQ <= '0; bPtrQ <= '0; resPtrQ <= '0;
      aLenQ <= '0; bLenQ <= '0; idx <= '0; cnt <= '0;
      opQ <= OP_COPY; msOneQ <= 1'b0; shiftQ <= '0;
      downQ <= 1'b0; twoQ <= 1'b0; rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= ramRdEn;
      case (state)
        S_IDLE: if (accept) begin
          aPtrQ <= aPtrIn; bPtrQ <= bPtrIn; resPtrQ <= resPtrIn;
          aLenQ <= CNT_W'(aLenIn); bLenQ <= CNT_W'(bLenIn);
          opQ <= opIn; msOneQ <= msOneIn; shiftQ <= shiftIn;
          downQ <= downIn; twoQ <= twoIn;
          cnt <= total;
          idx <= downIn ? total - 1'b1 : '0;
          state <= (total == '0) ? S_EMPTY : S_RDA;
        end
        S_RDA: state <= S_RDB;
        S_RDB: state <= S_EXEC;
        S_EXEC: begin
          if (finishWord) state <= S_DONE;
          else begin
            idx   <= downQ ? idx - 1'b1 : idx + 1'b1;
            cnt   <= cnt - 1'b1;
            state <= S_RDA;
          end
        end
        S_EMPTY: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ramRdEn   = ((state == S_RDA) && (idx < aLenQ)) ||
                ((state == S_RDB) && twoQ && (idx < bLenQ));
    ramRdAddr = ((state == S_RDB) ? bPtrQ : aPtrQ) + ADDR_W'(idx);
    ramWrEn   = (state == S_EXEC) && (opQ != OP_CMP);
    ramWrAddr = resPtrQ + ADDR_W'(idx);
    strb.clear   = accept;
    strb.capA    = (state == S_RDB);
    strb.exec    = (state == S_EXEC);
    strb.dataOk  = rdValidQ;
    strb.publish = finishWord || (state == S_EMPTY);
    strb.down    = downQ;
    busy = (state != S_IDLE);
    done = (state == S_DONE);
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R12: reads and writes never share a cycle
  a_r12_rw_excl: assert property (@(posedge clk) disable iff (!rstN) !(ramRdEn && ramWrEn));
  // R10: a start while running does not end the run
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy);
endmodule

// File: rtl/bnv_dp.sv
module bnv_dp
  import bnv_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int SH_W   = 5,
  parameter int MSW_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bnvStrobe_t        strb,
  input  logic [2:0]        opQ,
  input  logic              msOneQ,
  input  logic [SH_W-1:0]   shiftQ,
  input  logic [DATA_W-1:0] ramRdData,
  input  logic [ADDR_W-1:0] ramWrAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              cmpDiff,
  output logic [2:0]        cmpFlags,
  output logic [MSW_W-1:0]  mswStatus,
  output logic [SH_W-1:0]   msBitPos
);
  localparam logic [MSW_W-1:0] ZERO_MSW = MSW_W'(1) << (MSW_W - 1);

  function automatic logic [SH_W-1:0] topBit(input logic [DATA_W-1:0] v);
    logic [SH_W-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_W; i++) if (v[i]) r = SH_W'(i);
    return r;
  endfunction

  logic [DATA_W-1:0]   aWord, prevWord, opB, res;
  logic                carry, carryNext, cmpGt;
  logic [DATA_W:0]     sumW, difW;
  logic [2*DATA_W-1:0] lshW, rshW;
  logic                found, foundN, take;
  logic [ADDR_W-1:0]   trkAddr, addrN;
  logic [SH_W-1:0]     trkBit, bitN;
  logic [MSW_W-1:0]    mswNext;

  always_comb begin
    opB  = strb.dataOk ? ramRdData : '0;
    sumW = {1'b0, aWord} + {1'b0, opB} + (DATA_W+1)'(carry);
    difW = {1'b0, aWord} - {1'b0, opB} - (DATA_W+1)'(carry);
    lshW = {aWord, prevWord} << shiftQ;
    rshW = {prevWord, aWord} >> shiftQ;
    carryNext = 1'b0;
    case (opQ)
      OP_ADD: begin res = sumW[DATA_W-1:0]; carryNext = sumW[DATA_W]; end
      OP_SUB: begin res = difW[DATA_W-1:0]; carryNext = difW[DATA_W]; end
      OP_LSH: res = lshW[2*DATA_W-1:DATA_W];
      OP_RSH: res = rshW[DATA_W-1:0];
      default: res = aWord;
    endcase
    cmpDiff = (aWord != opB);
    cmpGt   = (aWord > opB);
    take    = strb.exec && (opQ != OP_CMP) && (res != '0) && (!strb.down || !found);
    foundN  = found || take;
    addrN   = take ? ramWrAddr : trkAddr;
    bitN    = take ? topBit(res) : trkBit;
    mswNext = '0;
    mswNext[ADDR_W-1:0] = addrN;
    if (!foundN) mswNext = ZERO_MSW;
  end

  assign ramWrData = res;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aWord <= '0; prevWord <= '0; carry <= 1'b0;
      found <= 1'b0; trkAddr <= '0; trkBit <= '0;
      cmpFlags <= '0; mswStatus <= ZERO_MSW; msBitPos <= '0;
    end else begin
      if (strb.clear) begin
        prevWord <= '0; carry <= 1'b0;
        found <= 1'b0; trkAddr <= '0; trkBit <= '0;
      end
      if (strb.capA) aWord <= strb.dataOk ? ramRdData : '0;
      if (strb.exec) begin
        carry <= carryNext; prevWord <= aWord;
        found <= foundN; trkAddr <= addrN; trkBit <= bitN;
      end
      if (strb.publish) begin
        if (opQ == OP_CMP)
          cmpFlags <= (strb.exec && cmpDiff) ? (cmpGt ? 3'b100 : 3'b010) : 3'b001;
        else begin
          mswStatus <= mswNext;
          if (msOneQ) msBitPos <= foundN ? bitN : '0;
        end
      end
    end
  end

  // R8: result outputs hold unless the control publishes
  a_r8_msw_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.publish |=> $stable(mswStatus));
  a_r8_cmp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.publish |=> $stable(cmpFlags));
  a_r8_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.publish |=> $stable(msBitPos));
  // R5: compare outcome is never multi-hot
  a_r5_cmp_onehot: assert property (@(posedge clk) disable iff (!rstN) $onehot0(cmpFlags));
  // R6: a zero result carries a cleared address field
  a_r6_zero_addr: assert property (@(posedge clk) disable iff (!rstN)
    mswStatus[MSW_W-1] |-> (mswStatus[ADDR_W-1:0] == '0));
endmodule

// File: rtl/bignum_vec_unit.sv
module bignum_vec_unit
  import bnv_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int LEN_W  = 9,
  parameter int DATA_W = 32,
  parameter int MSW_W  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [2:0]                 opSel,
  input  logic                       msOneReq,
  input  logic [$clog2(DATA_W)-1:0]  shiftAmt,
  input  logic [ADDR_W-1:0]          aPtr,
  input  logic [LEN_W-1:0]           aLen,
  input  logic [ADDR_W-1:0]          bPtr,
  input  logic [LEN_W-1:0]           bLen,
  input  logic [ADDR_W-1:0]          resPtr,
  output logic                       ramRdEn,
  output logic [ADDR_W-1:0]          ramRdAddr,
  input  logic [DATA_W-1:0]          ramRdData,
  output logic                       ramWrEn,
  output logic [ADDR_W-1:0]          ramWrAddr,
  output logic [DATA_W-1:0]          ramWrData,
  output logic                       busy,
  output logic                       done,
  output logic [2:0]                 cmpFlags,
  output logic [MSW_W-1:0]           mswStatus,
  output logic [$clog2(DATA_W)-1:0]  msBitPos
);
  localparam int SH_W = $clog2(DATA_W);

  bnvStrobe_t      strb;
  logic [2:0]      opQ;
  logic            msOneQ, cmpDiff;
  logic [SH_W-1:0] shiftQ;

  bnv_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SH_W(SH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opIn(opSel), .msOneIn(msOneReq),
    .shiftIn(shiftAmt), .aPtrIn(aPtr), .aLenIn(aLen), .bPtrIn(bPtr), .bLenIn(bLen),
    .resPtrIn(resPtr), .cmpDiff(cmpDiff), .strb(strb), .opQ(opQ), .msOneQ(msOneQ),
    .shiftQ(shiftQ), .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr), .ramWrEn(ramWrEn),
    .ramWrAddr(ramWrAddr), .busy(busy), .done(done)
  );

  bnv_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SH_W(SH_W), .MSW_W(MSW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opQ(opQ), .msOneQ(msOneQ), .shiftQ(shiftQ),
    .ramRdData(ramRdData), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .cmpDiff(cmpDiff), .cmpFlags(cmpFlags), .mswStatus(mswStatus), .msBitPos(msBitPos)
  );
endmodule

// File: tb/sim_bignum_vec_unit.sv
module sim_bignum_vec_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic        msOneReq = 1'b0;
  logic [4:0]  shiftAmt = '0;
  logic [10:0] aPtr = '0, bPtr = '0, resPtr = '0;
  logic [8:0]  aLen = '0, bLen = '0;
  logic        ramRdEn, ramWrEn, busy, done;
  logic [10:0] ramRdAddr, ramWrAddr;
  logic [31:0] ramRdData = '0, ramWrData;
  logic [2:0]  cmpFlags;
  logic [15:0] mswStatus;
  logic [4:0]  msBitPos;

  always #4 clk = ~clk;  // 125 MHz

  bignum_vec_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .msOneReq(msOneReq),
    .shiftAmt(shiftAmt), .aPtr(aPtr), .aLen(aLen), .bPtr(bPtr), .bLen(bLen),
    .resPtr(resPtr), .ramRdEn(ramRdEn), .ramRdAddr(ramRdAddr), .ramRdData(ramRdData),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData), .busy(busy),
    .done(done), .cmpFlags(cmpFlags), .mswStatus(mswStatus), .msBitPos(msBitPos)
  );

  logic [31:0] mem [0:2047];
  always @(posedge clk) begin
    if (ramRdEn) ramRdData <= mem[ramRdAddr];
    if (ramWrEn) mem[ramWrAddr] <= ramWrData;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor state
  bit          active = 0;
  int          cyc = 0, expCyc = 0;
  int          curAP, curAL, curBP, curBL;
  int          expWA[$];
  logic [31:0] expWD[$];
  logic [2:0]  heldCmp;
  logic [15:0] heldMsw;
  logic [4:0]  heldBit;

  always @(negedge clk) begin
    if (active) begin
      cyc++;
      if (cyc < expCyc) begin
        chk(!done && busy, "R9", "busy without done", {busy, done}, 2'b10);
        chk(cmpFlags == heldCmp && mswStatus == heldMsw && msBitPos == heldBit,
            "R8", "outputs stable while busy", {cmpFlags, mswStatus, msBitPos},
            {heldCmp, heldMsw, heldBit});
      end else begin
        chk(done && busy, "R9", "done in due cycle", {busy, done}, 2'b11);
        active = 0;
      end
      if (ramRdEn)
        chk((int'(ramRdAddr) >= curAP && int'(ramRdAddr) < curAP + curAL) ||
            (int'(ramRdAddr) >= curBP && int'(ramRdAddr) < curBP + curBL),
            "R12", "read in bounds", ramRdAddr, curAP);
    end
    if (ramWrEn) begin
      if (expWA.size() == 0) chk(0, "R1", "unexpected write", ramWrAddr, 0);
      else begin
        int ea;
        logic [31:0] ed;
        ea = expWA.pop_front();
        ed = expWD.pop_front();
        chk(int'(ramWrAddr) == ea && ramWrData == ed, "R1", "write addr/data",
            {ramWrAddr, ramWrData}, {ea[10:0], ed});
      end
    end
  end

  function automatic logic [31:0] rdw(input int p, input int l, input int i);
    return (i >= 0 && i < l) ? mem[(p + i) & 2047] : 32'd0;
  endfunction

  logic [2:0]  refCmp = 3'd0;
  logic [15:0] refMsw = 16'h8000;
  logic [4:0]  refBit = 5'd0;

  task automatic runOp(input int op, input int aP, input int aL, input int bP, input int bL,
                       input int rP, input int sh, input bit ms, input bit extraStart,
                       input string req);
    logic [31:0] res[$];
    int maxL, total, examined;
    longint acc;
    maxL = (aL > bL) ? aL : bL;
    examined = 0;
    case (op)
      1: total = maxL;
      2: total = maxL + 1;
      3: total = maxL;
      4: total = aL + 1;
      default: total = aL;
    endcase
    if (op == 1) begin
      logic [2:0] f;
      f = 3'b001;
      for (int i = maxL - 1; i >= 0; i--) begin
        examined++;
        if (rdw(aP, aL, i) != rdw(bP, bL, i)) begin
          f = (rdw(aP, aL, i) > rdw(bP, bL, i)) ? 3'b100 : 3'b010;
          break;
        end
      end
      refCmp = f;
    end else begin
      acc = 0;
      for (int i = 0; i < total; i++) begin
        logic [63:0] w;
        logic [31:0] a, b;
        a = rdw(aP, aL, i); b = rdw(bP, bL, i);
        case (op)
          2: begin acc = longint'(a) + longint'(b) + acc; res.push_back(acc[31:0]); acc = acc >>> 32; end
          3: begin acc = longint'(a) - longint'(b) - acc; res.push_back(acc[31:0]); acc = (acc < 0) ? 1 : 0; end
          4: begin w = {a, rdw(aP, aL, i - 1)} << sh; res.push_back(w[63:32]); end
          5: begin w = {rdw(aP, aL, i + 1), a} >> sh; res.push_back(w[31:0]); end
          default: res.push_back(a);
        endcase
      end
      for (int k = 0; k < total; k++) begin
        int i;
        i = (op == 5) ? total - 1 - k : k;
        expWA.push_back((rP + i) & 2047);
        expWD.push_back(res[i]);
      end
      refMsw = 16'h8000;
      if (ms) refBit = 5'd0;
      for (int j = total - 1; j >= 0; j--) begin
        if (res[j] != 0) begin
          refMsw = 16'((rP + j) & 2047);
          if (ms) for (int b = 0; b < 32; b++) if (res[j][b]) refBit = 5'(b);
          break;
        end
      end
    end
    @(negedge clk);
    opSel = 3'(op); aPtr = 11'(aP); aLen = 9'(aL); bPtr = 11'(bP); bLen = 9'(bL);
    resPtr = 11'(rP); shiftAmt = 5'(sh); msOneReq = ms; start = 1'b1;
    heldCmp = cmpFlags; heldMsw = mswStatus; heldBit = msBitPos;
    curAP = aP; curAL = aL; curBP = bP; curBL = (op == 1 || op == 2 || op == 3) ? bL : 0;
    expCyc = (total == 0) ? 2 : 3 * ((op == 1) ? examined : total) + 1;
    @(posedge clk);
    cyc = 0; active = 1;
    @(negedge clk);
    start = 1'b0;
    if (extraStart) begin
      // R10: a second request mid-run with other operands
      opSel = 3'd2; aPtr = 11'd700; aLen = 9'd3; resPtr = 11'd900; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (!active);
    chk(cmpFlags == refCmp, req, "cmpFlags", cmpFlags, refCmp);
    chk(mswStatus == refMsw, req, "mswStatus", mswStatus, refMsw);
    chk(msBitPos == refBit, req, "msBitPos", msBitPos, refBit);
    chk(expWA.size() == 0, req, "all writes seen", expWA.size(), 0);
    expWA.delete(); expWD.delete();
    @(negedge clk);
    chk(!busy && !done, "R9", "idle after done", {busy, done}, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !ramRdEn && !ramWrEn, "R11", "idle in reset",
        {busy, done, ramRdEn, ramWrEn}, 0);
    chk(cmpFlags == 3'd0 && mswStatus == 16'h8000 && msBitPos == 5'd0, "R11",
        "reset outputs", {cmpFlags, mswStatus, msBitPos}, {3'd0, 16'h8000, 5'd0});
    rstN = 1'b1;
    @(negedge clk);

    mem[16] = 32'h1234_5678; mem[17] = 32'h0000_00F0; mem[18] = 32'h8000_0001;
    runOp(0, 16, 3, 0, 0, 128, 0, 1, 0, "R1");                 // copy, top bit 31
    for (int i = 0; i < 4; i++) mem[32 + i] = 32'hFFFF_FFFF;
    mem[64] = 32'h1;
    runOp(2, 32, 4, 64, 1, 160, 0, 1, 0, "R2");                // carry ripples to extra word
    mem[40] = 32'h0; mem[41] = 32'h0; mem[42] = 32'h1;
    runOp(3, 40, 3, 64, 1, 192, 0, 1, 0, "R3");                // borrow through two words
    runOp(3, 64, 1, 64, 1, 224, 0, 1, 0, "R6");                // zero result
    runOp(4, 16, 3, 0, 0, 256, 4, 1, 0, "R4");                 // left shift 4
    runOp(5, 16, 3, 0, 0, 288, 31, 1, 0, "R4");                // right shift 31
    runOp(4, 16, 3, 0, 0, 320, 0, 0, 0, "R7");                 // shift 0, msOne off keeps bit
    // compares: equal, less at top, greater low with zero extension
    mem[80] = 32'h5; mem[81] = 32'h7; mem[84] = 32'h5; mem[85] = 32'h7;
    runOp(1, 80, 2, 84, 2, 0, 0, 1, 0, "R5");
    mem[86] = 32'h5; mem[87] = 32'h8;
    runOp(1, 80, 2, 86, 2, 0, 0, 1, 0, "R5");
    mem[88] = 32'h9; mem[89] = 32'h7; mem[90] = 32'h0;
    runOp(1, 88, 3, 80, 2, 0, 0, 1, 0, "R5");
    runOp(2, 32, 4, 64, 1, 352, 0, 1, 1, "R10");               // start while busy
    runOp(0, 16, 0, 0, 0, 384, 0, 1, 0, "R9");                 // zero-length operation
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule